// File: doc/BRIEF.md
# Character Raster Display Row Controller

This block produces the raster timing for a character-mapped text screen and keeps the displayed text in two small on-chip row stores. One store feeds the current row to an external character generator while the other is loaded with the next row from main memory through a request/acknowledge DMA handshake. At each row boundary the two stores change roles. The processor never touches display memory through this block. It only sends a short command stream that sets the screen format, the cursor position and the run state. After that, the scan proceeds by itself.

Every clock is one character time. In each character time the block gives the character code for the current column and the scan line number inside the current row. It also gives horizontal and vertical retrace flags, a cursor flag and a video-enable flag. If the DMA source is too slow and a row is not complete at its boundary, that row is shown blank and a sticky status bit is raised.

Top module: `crt_row_ctrl`

## Requirements
- R1: After reset, dma_req, video_en, cursor_vid, hretrace, vretrace and underrun are 0, char_code is 0 and line_cnt is 0. The scan is stopped.
- R2: A command byte (cpu_wr=1, cpu_cmd=1) of 0x00 stops the scan, clears underrun and makes the next five parameter bytes (cpu_cmd=0) set the format, in this order:
  - columns-1, clipped to 79;
  - rows-1, clipped to 63;
  - lines-1 in bits [3:0];
  - a byte with vertical retrace rows-1 in [7:4] and horizontal retrace characters-1 in [3:0];
  - the burst code in [1:0].
  Parameter bytes beyond those expected are ignored. Unknown command codes are ignored.
- R3: While running, the column advances once per clock. After the last column, hretrace is high for the programmed number of character times.
- R4: line_cnt steps from 0 to lines-1 once per full scan line and returns to 0 at the first clock of each row.
- R5: After the last displayed row, vretrace is high for the programmed number of rows. Each of these rows has the full row length.
- R6: dma_req is high while a row fill is in progress, except during a one-clock gap after each burst. A byte is taken on each clock with dma_req and dma_ack both high. A burst is 2^code bytes.
- R7: The fill for a displayed row starts on the first clock of the row before it. For row 0, that is the last retrace row. The fill ends after as many bytes as there are columns.
- R8: In a displayed row, column c shows on char_code the c-th byte taken during that row's fill, with video_en high.
- R9: If the fill is incomplete when its row starts, underrun is set and stays set until the next 0x00 command. That row shows video_en=0 and char_code=0.
- R10: Command 0x80 followed by two parameter bytes (row, then column) sets the cursor. cursor_vid is high on every scan line of that displayed row and column.
- R11: Command 0x20 starts the scan on the first clock of the last retrace row, with a fresh fill for row 0. Command 0x40 drops dma_req and video_en by the next clock and freezes the scan.
- R12: dma_ack is ignored when dma_req is low. A byte acknowledged on the last clock of a row is discarded, because the fill restarts at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Write strobe for the command port |
| cpu_cmd | input | 1 | 1: byte is a command, 0: byte is a parameter |
| cpu_data | input | 8 | Command or parameter byte |
| dma_req | output | 1 | DMA request for the row fill |
| dma_ack | input | 1 | DMA acknowledge, byte valid on dma_data |
| dma_data | input | 8 | Display byte from main memory |
| char_code | output | 8 | Character code to the character generator |
| line_cnt | output | 4 | Scan line within the current row |
| hretrace | output | 1 | Horizontal retrace |
| vretrace | output | 1 | Vertical retrace |
| cursor_vid | output | 1 | Cursor position on screen |
| video_en | output | 1 | Displayed character is valid |
| underrun | output | 1 | Sticky row fill underrun |

## Verification
The properties assume several things about the inputs:
- cpu_wr, cpu_cmd, cpu_data, dma_ack and dma_data change only between clock edges;
- a command byte is never mistaken for a parameter byte;
- dma_ack is meaningful only while dma_req is high, although a stray acknowledge must stay harmless.

The stimulus changes inputs on the falling edge only. It sends complete command sequences and adds one surplus parameter byte. It drives the acknowledge in several patterns: following the request every clock, on alternate clocks, and held high while the scan is stopped. The last pattern checks that stray acknowledges are ignored.

// File: rtl/crt_row_pkg.sv
package crt_row_pkg;

   // command codes on the processor port
   localparam logic [7:0] OP_FORMAT = 8'h00;
   localparam logic [7:0] OP_START  = 8'h20;
   localparam logic [7:0] OP_STOP   = 8'h40;
   localparam logic [7:0] OP_CURSOR = 8'h80;

   localparam int FMT_BYTES = 5;
   localparam int CUR_BYTES = 2;

   typedef struct packed {
      logic [7:0] cols_m1;
      logic [7:0] rows_m1;
      logic [3:0] lines_m1;
      logic [3:0] hret_m1;
      logic [3:0] vret_m1;
      logic [1:0] burst_code;
   } crt_fmt_t;

endpackage

// File: rtl/crt_cmd_regs.sv
module crt_cmd_regs
   import crt_row_pkg::*;
#(
   parameter int MAX_COLS = 80,
   parameter int MAX_ROWS = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       is_cmd,
   input  logic [7:0] data,
   output crt_fmt_t   fmt,
   output logic [7:0] cur_row,
   output logic [7:0] cur_col,
   output logic       run_en,
   output logic       start_p,
   output logic       clr_und
);

   localparam logic [7:0] COL_LIM = 8'(MAX_COLS - 1);
   localparam logic [7:0] ROW_LIM = 8'(MAX_ROWS - 1);

   logic [2:0] left;
   logic [2:0] idx;
   logic       kind_cur;
   logic       cmd_wr, par_wr;

   assign cmd_wr  = wr && is_cmd;
   assign par_wr  = wr && !is_cmd && (left != 3'd0);
   assign start_p = cmd_wr && (data == OP_START);
   assign clr_und = cmd_wr && (data == OP_FORMAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt      <= '{cols_m1: COL_LIM, rows_m1: 8'd24, lines_m1: 4'd9,
                       hret_m1: 4'd9, vret_m1: 4'd1, burst_code: 2'd0};
         cur_row  <= '0;
         cur_col  <= '0;
         run_en   <= 1'b0;
         left     <= '0;
         idx      <= '0;
         kind_cur <= 1'b0;
      end else if (cmd_wr) begin
         case (data)
            OP_FORMAT: begin
               run_en   <= 1'b0;
               left     <= 3'(FMT_BYTES);
               idx      <= '0;
               kind_cur <= 1'b0;
            end
            OP_CURSOR: begin
               left     <= 3'(CUR_BYTES);
               idx      <= '0;
               kind_cur <= 1'b1;
            end
            OP_START: run_en <= 1'b1;
            OP_STOP:  run_en <= 1'b0;
            default: ;
         endcase
      end else if (par_wr) begin
         left <= left - 3'd1;
         idx  <= idx + 3'd1;
         if (kind_cur) begin
            if (idx == 3'd0) cur_row <= data;
            else             cur_col <= data;
         end else begin
            case (idx)
               3'd0: fmt.cols_m1  <= (data > COL_LIM) ? COL_LIM : data;
               3'd1: fmt.rows_m1  <= (data > ROW_LIM) ? ROW_LIM : data;
               3'd2: fmt.lines_m1 <= data[3:0];
               3'd3: begin
                  fmt.vret_m1 <= data[7:4];
                  fmt.hret_m1 <= data[3:0];
               end
               default: fmt.burst_code <= data[1:0];
            endcase
         end
      end
   end

endmodule

// File: rtl/crt_scan_timing.sv
module crt_scan_timing
   import crt_row_pkg::*;
#(
   parameter int COL_W  = 7,
   parameter int ROW_W  = 7,
   parameter int LINE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              start_p,
   input  crt_fmt_t          fmt,
   output logic [COL_W-1:0]  hc,
   output logic [LINE_W-1:0] lc,
   output logic [ROW_W-1:0]  rc,
   output logic              row_end,
   output logic              show_next,
   output logic              fetch_next,
   output logic              active,
   output logic              hret_o,
   output logic              vret_o
);

   logic [COL_W-1:0] htot_m1;
   logic [ROW_W-1:0] tot_m1;
   logic [ROW_W-1:0] nxt, nxt2;
   logic             line_end;

   assign htot_m1  = COL_W'(fmt.cols_m1) + COL_W'(fmt.hret_m1) + COL_W'(1);
   assign tot_m1   = ROW_W'(fmt.rows_m1) + ROW_W'(fmt.vret_m1) + ROW_W'(1);
   assign line_end = (hc == htot_m1);
   assign row_end  = run_en && line_end && (lc == LINE_W'(fmt.lines_m1));
   assign nxt      = (rc == tot_m1) ? '0 : rc + ROW_W'(1);
   assign nxt2     = (nxt == tot_m1) ? '0 : nxt + ROW_W'(1);
   assign show_next  = (8'(nxt)  <= fmt.rows_m1);
   assign fetch_next = (8'(nxt2) <= fmt.rows_m1);

   assign hret_o = run_en && (8'(hc) > fmt.cols_m1);
   assign vret_o = run_en && (8'(rc) > fmt.rows_m1);
   assign active = run_en && !hret_o && !vret_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc <= '0;
         lc <= '0;
         rc <= '0;
      end else if (start_p) begin
         hc <= '0;
         lc <= '0;
         rc <= tot_m1;
      end else if (run_en) begin
         if (line_end) begin
            hc <= '0;
            if (row_end) begin
               lc <= '0;
               rc <= nxt;
            end else begin
               lc <= lc + LINE_W'(1);
            end
         end else begin
            hc <= hc + COL_W'(1);
         end
      end
   end

endmodule

// File: rtl/crt_row_fill.sv
module crt_row_fill
   import crt_row_pkg::*;
#(
   parameter int MAX_COLS = 80,
   parameter int COL_W    = 7,
   parameter int DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              start_p,
   input  logic              clr_und,
   input  logic              row_end,
   input  logic              show_next,
   input  logic              fetch_next,
   input  crt_fmt_t          fmt,
   input  logic [COL_W-1:0]  hc,
   input  logic              dma_ack,
   input  logic [DATA_W-1:0] dma_data,
   output logic              dma_req,
   output logic [DATA_W-1:0] rd_char,
   output logic              blank,
   output logic              underrun
);

   localparam int NBANK = 2;
   localparam int PTR_W = $clog2(MAX_COLS + 1);

   logic [PTR_W-1:0]  ptr;
   logic [2:0]        bcnt, burst_m1;
   logic              fill_act, done, gap, dsel;
   logic              take, wr_en;
   logic [PTR_W-1:0]  rd_idx;
   logic [DATA_W-1:0] bank_rd [NBANK];

   assign burst_m1 = 3'((4'd1 << fmt.burst_code) - 4'd1);
   assign dma_req  = run_en && fill_act && !gap;
   assign take     = dma_req && dma_ack;
   assign wr_en    = take && !start_p && !row_end;
   assign rd_idx   = (hc < COL_W'(MAX_COLS)) ? PTR_W'(hc) : '0;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DATA_W-1:0] mem [MAX_COLS];
      always_ff @(posedge clk) begin
         if (wr_en && (dsel != 1'(b)))
            mem[ptr] <= dma_data;
      end
      assign bank_rd[b] = mem[rd_idx];
   end

   assign rd_char = bank_rd[dsel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_act <= 1'b0;
         ptr      <= '0;
         done     <= 1'b0;
         bcnt     <= '0;
         gap      <= 1'b0;
         dsel     <= 1'b0;
         blank    <= 1'b1;
         underrun <= 1'b0;
      end else begin
         if (start_p) begin
            fill_act <= 1'b1;
            ptr      <= '0;
            done     <= 1'b0;
            bcnt     <= '0;
            gap      <= 1'b0;
            blank    <= 1'b1;
         end else if (row_end) begin
            if (show_next) begin
               if (done) begin
                  dsel  <= ~dsel;
                  blank <= 1'b0;
               end else begin
                  underrun <= 1'b1;
                  blank    <= 1'b1;
               end
            end
            fill_act <= fetch_next;
            ptr      <= '0;
            done     <= 1'b0;
            bcnt     <= '0;
            gap      <= 1'b0;
         end else if (take) begin
            ptr <= ptr + PTR_W'(1);
            if (8'(ptr) == fmt.cols_m1) begin
               fill_act <= 1'b0;
               done     <= 1'b1;
            end else if (bcnt == burst_m1) begin
               gap  <= 1'b1;
               bcnt <= '0;
            end else begin
               bcnt <= bcnt + 3'd1;
            end
         end else begin
            gap <= 1'b0;
         end
         if (clr_und) underrun <= 1'b0;
      end
   end

endmodule

// File: rtl/crt_row_ctrl.sv
module crt_row_ctrl
   import crt_row_pkg::*;
#(
   parameter int MAX_COLS  = 80,
   parameter int MAX_ROWS  = 64,
   parameter int MAX_LINES = 16,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_cmd,
   input  logic [7:0]        cpu_data,
   output logic              dma_req,
   input  logic              dma_ack,
   input  logic [DATA_W-1:0] dma_data,
   output logic [DATA_W-1:0] char_code,
   output logic [3:0]        line_cnt,
   output logic              hretrace,
   output logic              vretrace,
   output logic              cursor_vid,
   output logic              video_en,
   output logic              underrun
);

   localparam int RET_MAX = 16;
   localparam int COL_W   = $clog2(MAX_COLS + RET_MAX);
   localparam int ROW_W   = $clog2(MAX_ROWS + RET_MAX);
   localparam int LINE_W  = $clog2(MAX_LINES);

   if (MAX_COLS < 1 || MAX_COLS > 255) begin : g_bad_cols
      $error("MAX_COLS must be within 1..255");
   end
   if (MAX_ROWS < 1 || MAX_ROWS > 255 - RET_MAX) begin : g_bad_rows
      $error("MAX_ROWS out of range");
   end
   if (MAX_LINES != 16) begin : g_bad_lines
      $error("line field is four bits wide, MAX_LINES must be 16");
   end

   crt_fmt_t          fmt;
   logic [7:0]        cur_row, cur_col;
   logic              run_en, start_p, clr_und;
   logic [COL_W-1:0]  hc;
   logic [LINE_W-1:0] lc;
   logic [ROW_W-1:0]  rc;
   logic              row_end, show_next, fetch_next, active, blank;
   logic [DATA_W-1:0] rd_char;

   crt_cmd_regs #(.MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS)) i_cmd (
      .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .is_cmd(cpu_cmd), .data(cpu_data),
      .fmt(fmt), .cur_row(cur_row), .cur_col(cur_col), .run_en(run_en),
      .start_p(start_p), .clr_und(clr_und)
   );

   crt_scan_timing #(.COL_W(COL_W), .ROW_W(ROW_W), .LINE_W(LINE_W)) i_timing (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .start_p(start_p), .fmt(fmt),
      .hc(hc), .lc(lc), .rc(rc), .row_end(row_end), .show_next(show_next),
      .fetch_next(fetch_next), .active(active), .hret_o(hretrace),
      .vret_o(vretrace)
   );

   crt_row_fill #(.MAX_COLS(MAX_COLS), .COL_W(COL_W), .DATA_W(DATA_W)) i_fill (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .start_p(start_p),
      .clr_und(clr_und), .row_end(row_end), .show_next(show_next),
      .fetch_next(fetch_next), .fmt(fmt), .hc(hc), .dma_ack(dma_ack),
      .dma_data(dma_data), .dma_req(dma_req), .rd_char(rd_char),
      .blank(blank), .underrun(underrun)
   );

   assign line_cnt   = 4'(lc);
   assign video_en   = active && !blank;
   assign char_code  = video_en ? rd_char : '0;
   assign cursor_vid = active && (8'(rc) == cur_row) && (8'(hc) == cur_col);

endmodule

module crt_row_ctrl_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_wr,
   input logic       cpu_cmd,
   input logic [7:0] cpu_data,
   input logic       dma_req,
   input logic [3:0] line_cnt,
   input logic       hretrace,
   input logic       vretrace,
   input logic       cursor_vid,
   input logic       video_en,
   input logic       underrun,
   input logic       run_en
);
   import crt_row_pkg::*;

   a_r3_hret_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      hretrace |-> (!video_en && !cursor_vid));

   a_r5_vret_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      vretrace |-> (!video_en && !cursor_vid));

   a_r11_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_cmd && cpu_data == OP_STOP) |=>
         (!dma_req && !video_en && !hretrace && !vretrace));

   a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !(cpu_wr && cpu_cmd && cpu_data == OP_FORMAT)) |=> underrun);

   a_r2_format_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_cmd && cpu_data == OP_FORMAT) |=> (!underrun && !dma_req));

   a_r4_line_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && $past(run_en) && line_cnt != $past(line_cnt)) |->
         (line_cnt == $past(line_cnt) + 4'd1 || line_cnt == 4'd0));

   a_r6_req_only_running: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> run_en);

endmodule

bind crt_row_ctrl crt_row_ctrl_sva i_sva (
   .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_cmd(cpu_cmd),
   .cpu_data(cpu_data), .dma_req(dma_req), .line_cnt(line_cnt),
   .hretrace(hretrace), .vretrace(vretrace), .cursor_vid(cursor_vid),
   .video_en(video_en), .underrun(underrun), .run_en(run_en)
);

// File: tb/test_crt_row_ctrl.sv
module test_crt_row_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr = 1'b0, cpu_cmd = 1'b0;
   logic [7:0] cpu_data = 8'h00;
   logic       dma_req, dma_ack = 1'b0;
   logic [7:0] dma_data = 8'h00;
   logic [7:0] char_code;
   logic [3:0] line_cnt;
   logic       hretrace, vretrace, cursor_vid, video_en, underrun;

   int vectors = 0, errors = 0, cyc = 0;
   int ack_mode = 0;
   bit tog = 0, cmp_on = 0;
   logic [15:0] lfsr = 16'hACE1;

   crt_row_ctrl i_crt_row_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_cmd(cpu_cmd),
      .cpu_data(cpu_data), .dma_req(dma_req), .dma_ack(dma_ack),
      .dma_data(dma_data), .char_code(char_code), .line_cnt(line_cnt),
      .hretrace(hretrace), .vretrace(vretrace), .cursor_vid(cursor_vid),
      .video_en(video_en), .underrun(underrun)
   );

   always #10 clk = ~clk;  // 50 MHz

   // ---------------- behavioural reference ----------------
   int m_en, m_left, m_idx, m_kcur;
   int m_cols, m_rows, m_lines, m_hret, m_vret, m_burst, m_crow, m_ccol;
   int m_hc, m_lc, m_rc;
   int m_buf [2][80];
   int m_dsel, m_fact, m_fptr, m_fdone, m_bcnt, m_gap, m_blank, m_und;

   task automatic m_reset();
      m_en = 0; m_left = 0; m_idx = 0; m_kcur = 0;
      m_cols = 80; m_rows = 25; m_lines = 10; m_hret = 10; m_vret = 2;
      m_burst = 1; m_crow = 0; m_ccol = 0;
      m_hc = 0; m_lc = 0; m_rc = 0;
      m_dsel = 0; m_fact = 0; m_fptr = 0; m_fdone = 0; m_bcnt = 0;
      m_gap = 0; m_blank = 1; m_und = 0;
   endtask

   task automatic m_step();
      int htm1, totm1, nx, nx2, d;
      bit cw, is_fmt, is_start, is_stop, is_cur, take, rend;
      htm1  = m_cols + m_hret - 1;
      totm1 = m_rows + m_vret - 1;
      d     = cpu_data;
      cw    = cpu_wr && cpu_cmd;
      is_fmt   = cw && d == 8'h00;
      is_start = cw && d == 8'h20;
      is_stop  = cw && d == 8'h40;
      is_cur   = cw && d == 8'h80;
      take  = m_en != 0 && m_fact != 0 && m_gap == 0 && dma_ack;
      rend  = m_en != 0 && m_hc == htm1 && m_lc == m_lines - 1;
      nx    = (m_rc == totm1) ? 0 : m_rc + 1;
      nx2   = (nx == totm1) ? 0 : nx + 1;
      if (is_start) begin
         m_hc = 0; m_lc = 0; m_rc = totm1;
         m_fact = 1; m_fptr = 0; m_fdone = 0; m_bcnt = 0; m_gap = 0; m_blank = 1;
      end else begin
         if (rend) begin
            if (nx < m_rows) begin
               if (m_fdone != 0) begin m_dsel = 1 - m_dsel; m_blank = 0; end
               else begin m_und = 1; m_blank = 1; end
            end
            m_fact = (nx2 < m_rows); m_fptr = 0; m_fdone = 0; m_bcnt = 0; m_gap = 0;
         end else if (take) begin
            m_buf[1 - m_dsel][m_fptr] = dma_data;
            if (m_fptr == m_cols - 1) begin m_fact = 0; m_fdone = 1; end
            else if (m_bcnt == m_burst - 1) begin m_gap = 1; m_bcnt = 0; end
            else m_bcnt++;
            m_fptr++;
         end else m_gap = 0;
         if (m_en != 0) begin
            if (m_hc == htm1) begin
               m_hc = 0;
               if (rend) begin m_lc = 0; m_rc = nx; end else m_lc++;
            end else m_hc++;
         end
      end
      if (is_fmt) m_und = 0;
      // command port
      if (is_fmt) begin m_en = 0; m_left = 5; m_idx = 0; m_kcur = 0; end
      else if (is_cur) begin m_left = 2; m_idx = 0; m_kcur = 1; end
      else if (is_start) m_en = 1;
      else if (is_stop) m_en = 0;
      else if (cpu_wr && !cpu_cmd && m_left > 0) begin
         if (m_kcur != 0) begin
            if (m_idx == 0) m_crow = d; else m_ccol = d;
         end else begin
            case (m_idx)
               0: m_cols  = (d > 79 ? 79 : d) + 1;
               1: m_rows  = (d > 63 ? 63 : d) + 1;
               2: m_lines = (d % 16) + 1;
               3: begin m_vret = (d / 16) + 1; m_hret = (d % 16) + 1; end
               default: m_burst = 1 << (d % 4);
            endcase
         end
         m_idx++; m_left--;
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_reset();
      else m_step();
   end

   // ---------------- checking ----------------
   task automatic check(string tag, int got, int exp);
      vectors++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         bit act, ven;
         act = m_en != 0 && m_hc < m_cols && m_rc < m_rows;
         ven = act && m_blank == 0;
         check("R8/R9 video_en", video_en, ven);
         check("R8 char_code", char_code, ven ? m_buf[m_dsel][m_hc] : 0);
         check("R4 line_cnt", line_cnt, m_lc);
         check("R3 hretrace", hretrace, m_en != 0 && m_hc >= m_cols);
         check("R5 vretrace", vretrace, m_en != 0 && m_rc >= m_rows);
         check("R10 cursor_vid", cursor_vid, act && m_rc == m_crow && m_hc == m_ccol);
         check("R6/R7/R12 dma_req", dma_req, m_en != 0 && m_fact != 0 && m_gap == 0);
         check("R9 underrun", underrun, m_und);
      end
   end

   // DMA source: data changes every clock, acknowledge per pattern
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dma_data = lfsr[7:0];
      tog = ~tog;
      case (ack_mode)
         1: dma_ack = dma_req;
         2: dma_ack = dma_req && tog;
         3: dma_ack = 1'b1;
         default: dma_ack = 1'b0;
      endcase
   end

   task automatic put(bit is_c, logic [7:0] b);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_cmd = is_c; cpu_data = b;
      @(negedge clk);
      cpu_wr = 1'b0; cpu_cmd = 1'b0; cpu_data = 8'h00;
   endtask

   task automatic set_format(int c, int r, int l, int hv, int bc);
      put(1, 8'h00);
      put(0, 8'(c)); put(0, 8'(r)); put(0, 8'(l)); put(0, 8'(hv)); put(0, 8'(bc));
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R1: reset state
      check("R1 dma_req", dma_req, 0);
      check("R1 video_en", video_en, 0);
      check("R1 char_code", char_code, 0);
      check("R1 line_cnt", line_cnt, 0);
      check("R1 retrace", hretrace | vretrace, 0);
      check("R1 cursor/underrun", cursor_vid | underrun, 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      idle(2);

      // R2 R3 R4 R5 R6 R7 R8 R10: small screen, burst 2, acknowledge every clock
      ack_mode = 1;
      set_format(5, 2, 1, 8'h01, 1);
      put(0, 8'h05);            // surplus parameter, ignored (R2)
      put(1, 8'h13);            // unknown command, ignored (R2)
      put(1, 8'h80); put(0, 8'd1); put(0, 8'd2);   // cursor row 1 col 2 (R10)
      put(1, 8'h20);            // start (R11)
      idle(300);

      // R6 R7 R8 R10: longer rows, burst 8, acknowledge on alternate clocks
      ack_mode = 2;
      set_format(19, 3, 3, 8'h23, 3);
      put(1, 8'h20);
      idle(250);
      put(1, 8'h80); put(0, 8'd2); put(0, 8'd19);  // cursor moved while running
      idle(500);

      // R11 R12: stop, stray acknowledges, restart
      put(1, 8'h40);
      check("R11 dma_req after stop", dma_req, 0);
      check("R11 video_en after stop", video_en, 0);
      ack_mode = 3;
      idle(20);
      ack_mode = 2;
      put(1, 8'h20);
      idle(400);

      // R9: full width, one line per row, single-byte bursts -> underrun
      ack_mode = 1;
      set_format(200, 1, 0, 8'h00, 0);   // columns clipped to 80 (R2)
      put(1, 8'h20);
      idle(600);
      check("R9 underrun set", underrun, 1);
      check("R9 blank row", video_en, 0);
      set_format(3, 1, 1, 8'h10, 2);     // R2: format command clears underrun
      idle(1);
      check("R2 underrun cleared", underrun, 0);
      put(1, 8'h20);
      idle(200);

      cmp_on = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule